// File: doc/BRIEF.md
# Processor Status Flag Register

A 16-bit status word for a small processor core. Six condition flags are recomputed from an ALU operation whenever the update enable is raised. The inputs for that operation are both operands, the result, the carry or borrow out of the top bit, an operation class and a byte/word size select. Three control flags move only on dedicated per-flag set and clear strobes; ALU activity never touches them. A whole-word load restores every defined flag at once, for example on a context restore. The word is always readable on `psw_o`.

The layout is sparse. Bits 15..12 always read 1, and bits 1, 3 and 5 always read 0. In byte mode the sign, zero and overflow flags look at the low 8 bits and bit 7. In word mode they look at all 16 bits and bit 15. Parity always covers only the low result byte. All updates take effect on the clock edge after the command.

Top module: `psw_flag_reg`

## Requirements
- R1: After reset `psw_o` reads 16'hF000: every defined flag is 0.
- R2: Bits 15..12 of `psw_o` always read 1 and bits 1, 3, 5 always read 0, including after a load that writes the opposite values there.
- R3: With `load_i` high, the next cycle's flags at positions 0,2,4,6,7,8,9,10,11 equal `load_data_i` at those positions. The load takes precedence over any ALU update or control strobe in the same cycle.
- R4: Carry (bit 0) takes `carry_i` on add (`op_i`=0) and subtract (`op_i`=1). A logic operation (`op_i`=2) clears carry and overflow.
- R5: Parity (bit 2) is 1 when `res_i[7:0]` holds an even number of ones, and 0 otherwise, in both sizes.
- R6: Half-carry (bit 4) becomes `op_a_i[4]^op_b_i[4]^res_i[4]` on add/subtract and is left unchanged by a logic operation.
- R7: Zero (bit 6) is 1 when the result is zero over the selected width: `res_i[7:0]` when `byte_i`=1, or all of `res_i` when `byte_i`=0.
- R8: Sign (bit 7) copies the result's top bit: bit 7 in byte mode, bit 15 in word mode.
- R9: Overflow (bit 11) is set on add when both operands share a top bit that differs from the result's top bit. It is set on subtract when the operands' top bits differ and the result's top bit differs from the first operand's.
- R10: Control flags trap (bit 8), interrupt enable (bit 9) and direction (bit 10) are driven by `ctrl_set_i`/`ctrl_clr_i` index 0, 1 and 2 respectively. Clear wins over set, and ALU updates never change them.
- R11: Condition flags hold when `upd_i` is low, or when `op_i`=3 (no-op class), even if `upd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Recompute condition flags from the ALU inputs |
| op_i | input | 2 | Class: 0 add, 1 subtract, 2 logic, 3 no-op |
| byte_i | input | 1 | 1 = byte-size operation, 0 = word |
| op_a_i | input | 16 | First ALU operand |
| op_b_i | input | 16 | Second ALU operand |
| res_i | input | 16 | ALU result |
| carry_i | input | 1 | ALU carry/borrow out of the selected top bit |
| ctrl_set_i | input | 3 | Per-control-flag set strobes (0 trap, 1 int-enable, 2 direction) |
| ctrl_clr_i | input | 3 | Per-control-flag clear strobes, same order |
| load_i | input | 1 | Load the whole status word |
| load_data_i | input | 16 | Word to load |
| psw_o | output | 16 | Current status word |

## Verification
The hardest case to reach is several commands arriving in the same cycle. A load can coincide with an ALU update and with both set and clear strobes on the same control flag. The outcome then rests entirely on precedence. Random stimulus raises every command input independently in each cycle, so such overlaps occur often. Directed cycles also force the full overlap, a byte add that wraps to zero with a carry, and a word add that crosses into the sign bit.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int W      = 16;
  localparam int BYTE_W = 8;
  localparam int N_CTRL = 3;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;
  localparam int CTRL_BASE = 8;

  localparam logic [W-1:0] FIXED_ONES = 16'hF000;
  localparam logic [W-1:0] DEF_MASK   = 16'h0FD5;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } cond_t;
endpackage

// File: rtl/psw_cond_bits.sv
module psw_cond_bits
  import psw_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  op_e          op_i,
  input  logic         byte_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  input  logic         load_i,
  input  cond_t        load_val_i,
  output cond_t        q_o
);
  localparam int TOP = W - 1;
  localparam int BT  = BYTE_W - 1;

  cond_t q_q, nxt;
  logic  a_msb, b_msb, r_msb, r_zero, half_c;
  logic  unused_ops;

  assign unused_ops = ^{op_a_i[TOP-1:BYTE_W], op_a_i[BT-1:5], op_a_i[3:0],
                        op_b_i[TOP-1:BYTE_W], op_b_i[BT-1:5], op_b_i[3:0]};

  always_comb begin
    a_msb  = byte_i ? op_a_i[BT] : op_a_i[TOP];
    b_msb  = byte_i ? op_b_i[BT] : op_b_i[TOP];
    r_msb  = byte_i ? res_i[BT]  : res_i[TOP];
    r_zero = byte_i ? (res_i[BT:0] == '0) : (res_i == '0);
    half_c = op_a_i[4] ^ op_b_i[4] ^ res_i[4];

    nxt      = q_q;
    nxt.pf_f = ~^res_i[BT:0];
    nxt.zf_f = r_zero;
    nxt.sf_f = r_msb;
    unique case (op_i)
      OP_ADD: begin
        nxt.cf_f = carry_i;
        nxt.af_f = half_c;
        nxt.of_f = (a_msb == b_msb) && (r_msb != a_msb);
      end
      OP_SUB: begin
        nxt.cf_f = carry_i;
        nxt.af_f = half_c;
        nxt.of_f = (a_msb != b_msb) && (r_msb != a_msb);
      end
      OP_LOGIC: begin
        nxt.cf_f = 1'b0;
        nxt.of_f = 1'b0;
      end
      default: nxt = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          q_q <= '0;
    else if (load_i)                      q_q <= load_val_i;
    else if (upd_i && op_i != OP_NONE)    q_q <= nxt;
  end

  assign q_o = q_q;

  p_logic_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && op_i == OP_LOGIC) |=> (!q_o.cf_f && !q_o.of_f));

  p_logic_keeps_af_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && op_i == OP_LOGIC) |=> $stable(q_o.af_f));

  p_cond_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (!upd_i || op_i == OP_NONE)) |=> $stable(q_o));
endmodule

// File: rtl/psw_ctrl_bits.sv
module psw_ctrl_bits
  import psw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CTRL-1:0] set_i,
  input  logic [N_CTRL-1:0] clr_i,
  input  logic              load_i,
  input  logic [N_CTRL-1:0] load_val_i,
  output logic [N_CTRL-1:0] q_o
);
  for (genvar i = 0; i < N_CTRL; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (load_i)   f_q <= load_val_i[i];
      else if (clr_i[i]) f_q <= 1'b0;   // clear dominates set
      else if (set_i[i]) f_q <= 1'b1;
    end
    assign q_o[i] = f_q;

    p_clr_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && clr_i[i]) |=> !q_o[i]);
    p_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && set_i[i] && !clr_i[i]) |=> q_o[i]);
  end

  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/psw_flag_reg.sv
module psw_flag_reg
  import psw_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [1:0]   op_i,
  input  logic         byte_i,
  input  logic [15:0]  op_a_i,
  input  logic [15:0]  op_b_i,
  input  logic [15:0]  res_i,
  input  logic         carry_i,
  input  logic [2:0]   ctrl_set_i,
  input  logic [2:0]   ctrl_clr_i,
  input  logic         load_i,
  input  logic [15:0]  load_data_i,
  output logic [15:0]  psw_o
);
  cond_t             cond_ld, cond_q;
  logic [N_CTRL-1:0] ctrl_ld, ctrl_q;
  logic              unused_ld;

  assign cond_ld = '{of_f: load_data_i[OF_POS], sf_f: load_data_i[SF_POS],
                     zf_f: load_data_i[ZF_POS], af_f: load_data_i[AF_POS],
                     pf_f: load_data_i[PF_POS], cf_f: load_data_i[CF_POS]};
  assign ctrl_ld   = load_data_i[CTRL_BASE +: N_CTRL];
  assign unused_ld = ^{load_data_i[15:12], load_data_i[5], load_data_i[3], load_data_i[1]};

  psw_cond_bits u_cond (
    .clk_i, .rst_ni, .upd_i,
    .op_i      (op_e'(op_i)),
    .byte_i, .op_a_i, .op_b_i, .res_i, .carry_i, .load_i,
    .load_val_i(cond_ld),
    .q_o       (cond_q)
  );

  psw_ctrl_bits u_ctrl (
    .clk_i, .rst_ni,
    .set_i     (ctrl_set_i),
    .clr_i     (ctrl_clr_i),
    .load_i,
    .load_val_i(ctrl_ld),
    .q_o       (ctrl_q)
  );

  always_comb begin
    psw_o                        = FIXED_ONES;
    psw_o[CF_POS]                = cond_q.cf_f;
    psw_o[PF_POS]                = cond_q.pf_f;
    psw_o[AF_POS]                = cond_q.af_f;
    psw_o[ZF_POS]                = cond_q.zf_f;
    psw_o[SF_POS]                = cond_q.sf_f;
    psw_o[OF_POS]                = cond_q.of_f;
    psw_o[CTRL_BASE +: N_CTRL]   = ctrl_q;
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((psw_o & DEF_MASK) == ($past(load_data_i) & DEF_MASK)));

  p_ctrl_ignores_alu_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && ctrl_set_i == '0 && ctrl_clr_i == '0) |=> $stable(psw_o[10:8]));
endmodule

// File: tb/tb_psw_flag_reg.sv
module tb_psw_flag_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        byte_i = 1'b0;
  logic [15:0] op_a_i = '0, op_b_i = '0, res_i = '0, load_data_i = '0;
  logic        carry_i = 1'b0;
  logic [2:0]  ctrl_set_i = '0, ctrl_clr_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] psw_o;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_psw = 16'hF000;

  always #4 clk = ~clk;

  psw_flag_reg dut (
    .clk_i(clk), .rst_ni, .upd_i, .op_i, .byte_i, .op_a_i, .op_b_i, .res_i,
    .carry_i, .ctrl_set_i, .ctrl_clr_i, .load_i, .load_data_i, .psw_o
  );

  function automatic logic [15:0] model(logic [15:0] cur);
    logic [15:0] n = cur;
    int m = byte_i ? 7 : 15;
    if (load_i) n = load_data_i;
    else begin
      if (upd_i && op_i != 2'd3) begin
        n[2] = ~^res_i[7:0];
        n[6] = byte_i ? (res_i[7:0] == 8'd0) : (res_i == 16'd0);
        n[7] = res_i[m];
        if (op_i == 2'd2) begin
          n[0] = 1'b0; n[11] = 1'b0;
        end else begin
          n[0] = carry_i;
          n[4] = op_a_i[4] ^ op_b_i[4] ^ res_i[4];
          n[11] = (op_i == 2'd0) ? (op_a_i[m] == op_b_i[m] && res_i[m] != op_a_i[m])
                                 : (op_a_i[m] != op_b_i[m] && res_i[m] != op_a_i[m]);
        end
      end
      for (int i = 0; i < 3; i++)
        if (ctrl_clr_i[i]) n[8+i] = 1'b0;
        else if (ctrl_set_i[i]) n[8+i] = 1'b1;
    end
    n[15:12] = 4'hF; n[1] = 1'b0; n[3] = 1'b0; n[5] = 1'b0;
    return n;
  endfunction

  task automatic check(string tag);
    n_run++;
    if (psw_o !== exp_psw) begin
      n_fail++;
      $display("FAIL %s: psw_o=%h expected=%h", tag, psw_o, exp_psw);
    end
  endtask

  // inputs already driven; clock one edge and compare
  task automatic step(string tag);
    exp_psw = model(exp_psw);
    @(posedge clk); #2;
    check(tag);
  endtask

  task automatic idle();
    upd_i = 0; load_i = 0; ctrl_set_i = '0; ctrl_clr_i = '0;
  endtask

  task automatic alu(logic [1:0] op, logic bm, logic [15:0] a, logic [15:0] b,
                     logic [15:0] r, logic c, string tag);
    idle(); upd_i = 1; op_i = op; byte_i = bm;
    op_a_i = a; op_b_i = b; res_i = r; carry_i = c;
    step(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2; check("R1 reset");
    rst_ni = 1'b1;
    @(posedge clk); #2; check("R1 after release");

    idle(); load_i = 1; load_data_i = 16'hFFFF; step("R2 R3 load ones");
    idle(); load_i = 1; load_data_i = 16'h002A; step("R2 load fixed-zero bits");
    idle(); load_i = 1; load_data_i = 16'h0000; step("R3 load zero");

    // byte add 0x80+0x80 -> 0x00, carry out
    alu(2'd0, 1'b1, 16'h1280, 16'h3480, 16'hA600, 1'b1, "R7 R9 R4 byte wrap");
    // word add 0x7FFF+1 -> 0x8000
    alu(2'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, "R8 R9 R6 word sign");
    // byte sub 0x80-0x01 -> 0x7F
    alu(2'd1, 1'b1, 16'h0080, 16'h0001, 16'h007F, 1'b0, "R9 sub overflow");
    alu(2'd1, 1'b1, 16'h0000, 16'h0001, 16'h00FF, 1'b1, "R4 borrow");
    alu(2'd2, 1'b0, 16'h00F0, 16'h0F00, 16'h0000, 1'b1, "R4 R6 logic clears");
    alu(2'd0, 1'b0, 16'h0000, 16'h0000, 16'h0300, 1'b0, "R5 parity low byte only");
    alu(2'd0, 1'b1, 16'h0000, 16'h0000, 16'hFF00, 1'b0, "R7 byte zero high ignored");
    alu(2'd3, 1'b0, 16'hFFFF, 16'hFFFF, 16'h1234, 1'b1, "R11 no-op class");
    idle(); upd_i = 0; op_i = 2'd0; res_i = 16'h0000; carry_i = 1; step("R11 upd low");

    idle(); ctrl_set_i = 3'b111; step("R10 set all");
    alu(2'd2, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, "R10 alu leaves ctrl");
    idle(); ctrl_set_i = 3'b010; ctrl_clr_i = 3'b011; step("R10 clear wins");
    idle(); ctrl_set_i = 3'b101; step("R10 index map");
    idle(); load_i = 1; load_data_i = 16'h0000; upd_i = 1; op_i = 2'd0;
    res_i = 16'h0080; carry_i = 1; ctrl_set_i = 3'b111; step("R3 load precedence");

    for (int k = 0; k < 3000; k++) begin
      idle();
      upd_i      = ($urandom % 4) != 0;
      op_i       = 2'($urandom);
      byte_i     = 1'($urandom);
      op_a_i     = 16'($urandom);
      op_b_i     = 16'($urandom);
      if ($urandom % 2) begin
        logic [16:0] s;
        s = (op_i == 2'd1) ? ({1'b0, op_a_i} - {1'b0, op_b_i}) : ({1'b0, op_a_i} + {1'b0, op_b_i});
        res_i   = s[15:0];
        carry_i = byte_i ? (op_a_i[8] ^ op_b_i[8] ^ s[8]) : s[16];
      end else begin
        res_i   = ($urandom % 8 == 0) ? 16'h0 : 16'($urandom);
        carry_i = 1'($urandom);
      end
      ctrl_set_i  = 3'($urandom);
      ctrl_clr_i  = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
      load_i      = ($urandom % 10) == 0;
      load_data_i = 16'($urandom);
      step("R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule